// File: doc/BRIEF.md
# Serial Audio Receiver with Silence Flag

The block receives stereo PCM over a three-wire serial link: a bit clock, a word-select line and one data line. It runs entirely from the bit clock. The bit clock is normally 64 times the sample rate, which gives 32 bit slots per channel. A static format input selects either I2S framing or left-justified framing. Each channel word is assembled MSB first into a 24-bit two's-complement sample. When the sender supplies fewer than 24 bits, the missing low bits are filled with zeros. Bits beyond the 24th are dropped.

Once per stereo frame, the left and right samples are offered together on a valid/ready output. The serial link cannot be stalled, so the rules for back-pressure are fixed:
- The output holds its samples stable while valid is high and ready is low.
- A frame that completes while the previous frame is still pending is discarded.
- Valid falls after an accepted handshake unless a new frame loads in the same cycle.

A silence watcher counts consecutive stereo frames in which both samples are zero. It raises a status flag when the count reaches a threshold, 8192 by default.

Top module: `pcm_serial_rx`

## Requirements
- R1: With `fmt_lj` = 0 (I2S), the MSB of a word is the data bit sampled on the second rising bit-clock edge after a word-select change. The bit sampled on the edge that sees the change is not part of the new word.
- R2: With `fmt_lj` = 1 (left-justified), the MSB is the data bit sampled on the same rising edge that first sees the word-select change.
- R3: Words received while word-select is low are left samples, and words received while it is high are right samples. `out_left` and `out_right` are each 24 bits, bit 23 = MSB.
- R4: A word that ends, through a word-select change, before 24 bits have arrived is zero-padded in its least significant bits.
- R5: Data bits after the 24th bit of a word are ignored and do not alter the sample.
- R6: Word-select and data are sampled on rising bit-clock edges. A frame completes on the edge that samples the high-to-low word-select change following its right word, and `out_valid`/samples update on that edge. A frame needs a left word that began at a word-select change after reset.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_left` and `out_right` stay unchanged. A frame completing in that state is dropped.
- R8: After a cycle with `out_valid`=1 and `out_ready`=1, `out_valid` is 0 unless a new frame completed on that edge.
- R9: `zero_det` rises on the edge where the ZERO_FRAMES-th consecutive frame with both samples zero completes.
- R10: A completed frame with either sample nonzero clears `zero_det` on that edge and restarts the count.
- R11: The zero-frame count saturates. `zero_det` stays high through any number of further zero frames.
- R12: After reset, `out_valid`=0, `zero_det`=0 and both samples are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_lj | input | 1 | Framing select: 0 = I2S, 1 = left-justified (static) |
| ws | input | 1 | Word select: low = left, high = right |
| sd | input | 1 | Serial data, MSB first |
| out_valid | output | 1 | A stereo sample pair is offered |
| out_ready | input | 1 | Consumer accepts the pair |
| out_left | output | SAMPLE_W | Left sample, two's complement |
| out_right | output | SAMPLE_W | Right sample, two's complement |
| zero_det | output | 1 | Long run of silent frames seen |

## Verification
The bench builds the receiver with the default 24-bit sample width and lowers ZERO_FRAMES to 4. This makes the rise of the silence flag, its saturation and its clearing by a single nonzero frame reachable in a few dozen frames rather than 8192.

The bench drives both framings with several slot lengths:
- short words, to exercise zero padding;
- 40-cycle slots, to exercise discarding of surplus bits;
- held ready, to exercise dropped frames and stable outputs.

A behavioural model built on a bit queue predicts every output on every clock.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;

  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_LJ  = 1'b1
  } pcmrx_fmt_e;

  // number of bit clocks between the word-select change and the MSB
  function automatic int unsigned msb_lag(pcmrx_fmt_e f);
    return (f == FMT_LJ) ? 0 : 1;
  endfunction

endpackage

// File: rtl/pcmrx_deser.sv
module pcmrx_deser
  import pcmrx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pcmrx_fmt_e          fmt,
  input  logic                ws,
  input  logic                sd,
  output logic                word_done,
  output logic                word_right,
  output logic [SAMPLE_W-1:0] word_data
);

  localparam int unsigned POS_MAX = SAMPLE_W + 1;
  localparam int unsigned PW      = $clog2(POS_MAX + 1);
  localparam int unsigned KW      = PW + 1;

  logic                ws_q;
  logic                started_q;
  logic [PW-1:0]       pos_q, pos_d;
  logic [SAMPLE_W-1:0] acc_q, acc_d, acc_base;
  logic                ws_change;
  logic [KW-1:0]       lag;
  logic [KW-1:0]       slot_k;
  logic                in_word;

  assign ws_change = (ws != ws_q);
  assign lag       = KW'(msb_lag(fmt));

  // bit position counted from the word-select change, saturating
  always_comb begin
    if (ws_change)                  pos_d = '0;
    else if (pos_q == PW'(POS_MAX)) pos_d = pos_q;
    else                            pos_d = pos_q + 1'b1;
  end

  assign slot_k   = {1'b0, pos_d} - lag;
  assign in_word  = ({1'b0, pos_d} >= lag) && (slot_k < KW'(SAMPLE_W));
  assign acc_base = ws_change ? '0 : acc_q;

  // each sample bit picks up the serial bit only in its own slot
  for (genvar g = 0; g < SAMPLE_W; g++) begin : g_bit
    assign acc_d[g] = (in_word && (slot_k == KW'(SAMPLE_W - 1 - g))) ? sd : acc_base[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q      <= 1'b0;
      started_q <= 1'b0;
      pos_q     <= '0;
      acc_q     <= '0;
    end else begin
      ws_q      <= ws;
      started_q <= started_q | ws_change;
      pos_q     <= pos_d;
      acc_q     <= acc_d;
    end
  end

  assign word_done  = started_q && ws_change;
  assign word_right = ws_q;
  assign word_data  = acc_q;

endmodule

// File: rtl/pcmrx_pair.sv
module pcmrx_pair #(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_done,
  input  logic                word_right,
  input  logic [SAMPLE_W-1:0] word_data,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic                frame_done,
  output logic                frame_zero
);

  logic [SAMPLE_W-1:0] left_hold_q;
  logic                left_ok_q;
  logic                load;

  assign frame_done = word_done && word_right && left_ok_q;
  assign frame_zero = (left_hold_q == '0) && (word_data == '0);
  assign load       = frame_done && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold_q <= '0;
      left_ok_q   <= 1'b0;
    end else if (word_done) begin
      if (!word_right) begin
        left_hold_q <= word_data;
        left_ok_q   <= 1'b1;
      end else begin
        left_ok_q   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_left  <= left_hold_q;
      out_right <= word_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)))
    else $error("R7 output changed under back-pressure");

  p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !frame_done) |=> !out_valid)
    else $error("R8 valid stayed high after handshake");

endmodule

// File: rtl/pcmrx_zero_watch.sv
module pcmrx_zero_watch #(
  parameter int unsigned ZERO_FRAMES = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  input  logic frame_zero,
  output logic zero_det
);

  localparam int unsigned CW = $clog2(ZERO_FRAMES + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      zero_det <= 1'b0;
    end else if (frame_done) begin
      if (frame_zero) begin
        if (run_q != CW'(ZERO_FRAMES)) run_q <= run_q + 1'b1;
        zero_det <= (run_q >= CW'(ZERO_FRAMES - 1));
      end else begin
        run_q    <= '0;
        zero_det <= 1'b0;
      end
    end
  end

  p_zero_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_det) |-> $past(frame_done && frame_zero))
    else $error("R9 flag rose without a zero frame");

  p_zero_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_zero) |=> !zero_det)
    else $error("R10 flag survived a nonzero frame");

  p_run_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CW'(ZERO_FRAMES))
    else $error("R11 run counter passed its limit");

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcmrx_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned ZERO_FRAMES = 8192
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic                fmt_lj,
  input  logic                ws,
  input  logic                sd,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic                zero_det
);

  logic                word_done;
  logic                word_right;
  logic [SAMPLE_W-1:0] word_data;
  logic                frame_done;
  logic                frame_zero;

  pcmrx_deser #(.SAMPLE_W(SAMPLE_W)) u_deser (
    .clk        (bclk),
    .rst_n      (rst_n),
    .fmt        (pcmrx_fmt_e'(fmt_lj)),
    .ws         (ws),
    .sd         (sd),
    .word_done  (word_done),
    .word_right (word_right),
    .word_data  (word_data)
  );

  pcmrx_pair #(.SAMPLE_W(SAMPLE_W)) u_pair (
    .clk        (bclk),
    .rst_n      (rst_n),
    .word_done  (word_done),
    .word_right (word_right),
    .word_data  (word_data),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_left   (out_left),
    .out_right  (out_right),
    .frame_done (frame_done),
    .frame_zero (frame_zero)
  );

  pcmrx_zero_watch #(.ZERO_FRAMES(ZERO_FRAMES)) u_zero (
    .clk        (bclk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .frame_zero (frame_zero),
    .zero_det   (zero_det)
  );

endmodule

// File: tb/pcm_serial_rx_tb.sv
`timescale 1ns/1ps
module pcm_serial_rx_tb;

  localparam int SW = 24;
  localparam int ZF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fmt_lj = 1'b0;
  logic ws = 1'b0;
  logic sd = 1'b0;
  logic out_ready = 1'b0;
  logic out_valid;
  logic [SW-1:0] out_left, out_right;
  logic zero_det;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R12";

  always #10 clk = ~clk;

  pcm_serial_rx #(.SAMPLE_W(SW), .ZERO_FRAMES(ZF)) u_dut (
    .bclk(clk), .rst_n(rst_n), .fmt_lj(fmt_lj), .ws(ws), .sd(sd),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right), .zero_det(zero_det)
  );

  // ---------------- behavioural reference ----------------
  bit q[$];
  bit m_prev_ws, m_started, m_left_ok, rst_seen;
  logic [SW-1:0] m_left, exp_l, exp_r;
  bit exp_valid, exp_zero;
  int m_run;

  function automatic logic [SW-1:0] build_word();
    logic [SW-1:0] w = '0;
    int lagv = fmt_lj ? 0 : 1;
    for (int i = 0; i < SW; i++) begin
      int idx = i + lagv;
      w = {w[SW-2:0], (idx < q.size()) ? q[idx] : 1'b0};
    end
    return w;
  endfunction

  always @(posedge clk) begin
    rst_seen <= rst_n;
    if (!rst_n) begin
      m_prev_ws = 0; m_started = 0; m_left_ok = 0; q.delete();
      m_left = '0; exp_l = '0; exp_r = '0; exp_valid = 0; exp_zero = 0; m_run = 0;
    end else begin
      bit v_old, loaded, ws_now;
      logic [SW-1:0] w;
      v_old = exp_valid; loaded = 0; ws_now = ws;
      if (m_started && ws_now != m_prev_ws) begin
        w = build_word();
        if (!m_prev_ws) begin
          m_left = w; m_left_ok = 1;
        end else begin
          if (m_left_ok) begin
            if (!v_old || out_ready) begin exp_l = m_left; exp_r = w; loaded = 1; end
            if (m_left == 0 && w == 0) begin if (m_run < ZF) m_run++; end
            else m_run = 0;
            exp_zero = (m_run >= ZF);
          end
          m_left_ok = 0;
        end
      end
      exp_valid = loaded ? 1 : (v_old && !out_ready);
      if (ws_now != m_prev_ws) begin m_started = 1; q.delete(); end
      q.push_back(sd);
      m_prev_ws = ws_now;
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_seen) begin
      checks++;
      if (out_valid !== exp_valid || out_left !== exp_l || out_right !== exp_r || zero_det !== exp_zero) begin
        fails++;
        $display("FAIL %s model: actual v=%0b l=%h r=%h z=%0b expected v=%0b l=%h r=%h z=%0b",
                 cur_req, out_valid, out_left, out_right, zero_det, exp_valid, exp_l, exp_r, exp_zero);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic do_reset(bit f);
    @(negedge clk);
    rst_n = 0; fmt_lj = f; ws = 0; sd = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send_slot(bit wsv, logic [31:0] w, int nbits, int slot_len);
    for (int j = 0; j < slot_len; j++) begin
      @(negedge clk);
      ws = wsv;
      if (!fmt_lj) begin
        if (j == 0) sd = 1'b1;  // tail bit of the previous slot, must be dropped
        else sd = ((j - 1) < nbits) ? w[31 - (j - 1)] : 1'b0;
      end else begin
        sd = (j < nbits) ? w[31 - j] : 1'b0;
      end
    end
  endtask

  task automatic pulse_ready();
    @(negedge clk); out_ready = 1;
    @(negedge clk); out_ready = 0;
    check("R8 valid after handshake", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL R6 watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    do_reset(1'b0);
    @(negedge clk);
    check("R12 valid", {31'd0, out_valid}, 32'd0);
    check("R12 zero", {31'd0, zero_det}, 32'd0);
    check("R12 samples", {8'd0, out_left | out_right}, 32'd0);

    cur_req = "R6";
    send_slot(1, 32'hFFFFFFFF, 24, 32);  // priming right word, no frame
    cur_req = "R1";
    send_slot(0, 32'h123456AB, 24, 32);
    send_slot(1, 32'hFEDCBA98, 24, 32);
    send_slot(0, 32'h0F0F0F00, 24, 32);
    check("R1 valid", {31'd0, out_valid}, 32'd1);
    check("R1 left", {8'd0, out_left}, 32'h00123456);
    check("R3 right", {8'd0, out_right}, 32'h00FEDCBA);

    cur_req = "R7";
    send_slot(1, 32'h11111100, 24, 32);
    send_slot(0, 32'hABCDFFFF, 16, 32);
    check("R7 left held", {8'd0, out_left}, 32'h00123456);
    check("R7 right held", {8'd0, out_right}, 32'h00FEDCBA);
    pulse_ready();

    cur_req = "R4";
    send_slot(1, 32'h12345FFF, 20, 32);
    send_slot(0, 32'h89ABCDEF, 32, 40);
    check("R4 left padded", {8'd0, out_left}, 32'h00ABCD00);
    check("R4 right padded", {8'd0, out_right}, 32'h00123450);
    pulse_ready();

    cur_req = "R5";
    send_slot(1, 32'h7654321F, 32, 40);
    send_slot(0, 32'h00000000, 24, 32);
    check("R5 left", {8'd0, out_left}, 32'h0089ABCD);
    check("R5 right", {8'd0, out_right}, 32'h00765432);

    do_reset(1'b1);
    cur_req = "R2";
    send_slot(1, 32'h5A5A5A5A, 24, 32);
    send_slot(0, 32'hC0FFEE55, 24, 32);
    send_slot(1, 32'h800001FF, 32, 32);
    send_slot(0, 32'h00000000, 24, 32);
    check("R2 left", {8'd0, out_left}, 32'h00C0FFEE);
    check("R2 right", {8'd0, out_right}, 32'h00800001);

    cur_req = "R9";
    @(negedge clk); out_ready = 1;
    for (int i = 1; i <= 8; i++) begin
      send_slot(1, 32'h0, 24, 32);
      send_slot(0, 32'h0, 24, 32);
      if (i == 3) check("R9 below threshold", {31'd0, zero_det}, 32'd0);
      if (i == 4) check("R9 at threshold", {31'd0, zero_det}, 32'd1);
      if (i == 8) check("R11 saturated", {31'd0, zero_det}, 32'd1);
    end

    cur_req = "R10";
    send_slot(1, 32'h00000100, 24, 32);
    send_slot(0, 32'h0, 24, 32);
    check("R10 cleared", {31'd0, zero_det}, 32'd0);
    send_slot(1, 32'h0, 24, 32);
    send_slot(0, 32'h0, 24, 32);
    check("R10 restart", {31'd0, zero_det}, 32'd0);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule